// File: doc/BRIEF.md
# LIN-Capable Serial Character Transmitter

This block turns words offered on a valid/ready input into an asynchronous serial line. Each character has one low start bit, 5 to 9 data bits sent least significant bit first, an optional even or odd parity bit, and one or two high stop bits. The line rests high. Bit timing comes from an outside baud tick. Each bit lasts `OVS` ticks, and the tick count is also used to find the middle of the bit. One word can wait in a holding slot while another is shifted out, so characters follow each other with no idle gap.

For a bus host role, a per-word command changes what a single write produces. The write can send only a break field: 13 low bit times and then one high delimiter bit time. It can also send a whole header: the break, then a 0x55 sync character, then the written word as the identifier character, all in the configured character format. When collision checking is on, the looped-back receive line is compared with the driven bit at the middle of every bit time. A mismatch stops the transmission at once, empties the holding slot, clears the transmitter enable and raises a sticky collision flag. When the transmitter is disabled, no new words are accepted, but the characters already in flight and already held are still sent.

Top module: `lin_uart_tx`

## Requirements
- R1: After reset, `txd` is 1 and `busy`, `tx_on`, `coll_flag` and `in_ready` are all 0.
- R2: A normal character is a start bit of 0, then the data bits least significant bit first, then the stop bits of 1. Each bit holds for `OVS` baud ticks. The character size code gives the data bit count: 0→8, 1→9, 5→5, 6→6, 7→7, and the reserved codes 2, 3 and 4 → 8.
- R3: With `par_en`=1, a parity bit follows the data bits. With `par_odd`=0 the data bits plus the parity bit hold an even number of ones. With `par_odd`=1 they hold an odd number.
- R4: `two_stop`=0 sends one stop bit and `two_stop`=1 sends two. The next queued character's start bit comes directly after the last stop bit.
- R5: A word accepted with `lin_cmd`=1 sends only a break: 13 bit times of 0 and then 1 bit time of 1. The word's data is not sent.
- R6: A word accepted with `lin_cmd`=2 sends the break field, then a character carrying 0x55, then a character carrying the word, both characters in the configured format. `lin_cmd`=0 and `lin_cmd`=3 send a normal character.
- R7: One word can be held while another is shifting. `in_ready` is 0 while the holding slot is full.
- R8: An `en_clr` pulse makes `tx_on` and `in_ready` 0. The character in flight and the held character are still sent in full, and `busy` then falls.
- R9: A word offered in the same cycle as an `en_clr` pulse is not accepted: `in_ready` is 0 in that cycle and no frame follows.
- R10: With `coll_en`=1, if `rxd_loop` differs from `txd` at the middle of a bit, `txd` returns to 1, the held word is dropped, `busy` and `tx_on` go to 0, and `coll_flag` goes to 1.
- R11: With `coll_en`=0, differences between `rxd_loop` and `txd` have no effect on the frame or on `coll_flag`.
- R12: An `en_set` pulse sets `tx_on` and clears `coll_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | Oversampling tick, `OVS` per bit |
| en_set | input | 1 | Pulse: enable the transmitter, clear the collision flag |
| en_clr | input | 1 | Pulse: disable the transmitter after draining |
| char_size | input | 3 | Character size code |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 0 even parity, 1 odd parity |
| two_stop | input | 1 | 0 one stop bit, 1 two stop bits |
| lin_cmd | input | 2 | Per-word command: 0 normal, 1 break only, 2 full header |
| coll_en | input | 1 | Enable collision checking |
| in_data | input | 9 | Word to send (identifier for a header) |
| in_valid | input | 1 | Word offered |
| in_ready | output | 1 | Word can be accepted |
| rxd_loop | input | 1 | Looped-back line for collision checking |
| txd | output | 1 | Serial line, idle high |
| busy | output | 1 | A character is shifting or held |
| tx_on | output | 1 | Transmitter enable state |
| coll_flag | output | 1 | Sticky collision indication |

## Verification
Two events can land on the same clock edge. The first is a disable pulse arriving together with an offered word. The bench raises both in one cycle and then watches the line for a long window, judging that no start bit appears and that `busy` stays low. The second is the holding slot being emptied into the shifter while a new word is offered. The bench forks the capture against two back-to-back pushes over every size, parity and stop setting, then compares every mid-bit sample against a frame it builds arithmetically. A collision is forced while a second word is waiting, to show that the waiting word is dropped and not sent.

// File: rtl/lin_tx_pkg.sv
package lin_tx_pkg;
  typedef enum logic [1:0] {
    CMD_PLAIN  = 2'd0,
    CMD_BREAK  = 2'd1,
    CMD_HEADER = 2'd2,
    CMD_SPARE  = 2'd3
  } lin_cmd_e;

  localparam int BRK_LOW = 13;

  // number of data bits for a size code; reserved codes fall back to 8
  function automatic int data_bits(input logic [2:0] code);
    case (code)
      3'd1:    return 9;
      3'd5:    return 5;
      3'd6:    return 6;
      3'd7:    return 7;
      default: return 8;
    endcase
  endfunction
endpackage

// File: rtl/lin_tx_frame.sv
module lin_tx_frame
  import lin_tx_pkg::*;
#(
  parameter int MAXD = 9,
  parameter int CW   = MAXD + 4,
  parameter int LW   = 6
) (
  input  logic [MAXD-1:0] data,
  input  logic [2:0]      char_size,
  input  logic            par_en,
  input  logic            par_odd,
  input  logic            two_stop,
  output logic [CW-1:0]   low_mask,
  output logic [LW-1:0]   len
);
  // low_mask bit k = 1 means line bit k is driven low
  int  nb;
  logic par;
  always_comb begin
    nb       = data_bits(char_size);
    par      = par_odd;
    low_mask = '0;
    low_mask[0] = 1'b1;
    for (int i = 0; i < MAXD; i++) begin
      if (i < nb) begin
        low_mask[1+i] = ~data[i];
        par           = par ^ data[i];
      end
    end
    if (par_en) low_mask[1+nb] = ~par;
    len = LW'(2 + nb + int'(par_en) + int'(two_stop));
  end
endmodule

// File: rtl/lin_tx_serial.sv
module lin_tx_serial #(
  parameter int OVS = 4,
  parameter int FW  = 40,
  parameter int LW  = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          baud_tick,
  input  logic          coll_en,
  input  logic          rxd_loop,
  input  logic          ld_valid,
  input  logic [FW-1:0] ld_mask,
  input  logic [LW-1:0] ld_len,
  output logic          ld_take,
  output logic          coll_hit,
  output logic          active,
  output logic          txd
);
  localparam int SW = (OVS > 1) ? $clog2(OVS) : 1;
  localparam logic [SW-1:0] SUB_LAST = SW'(OVS - 1);
  localparam logic [SW-1:0] SUB_MID  = SW'(OVS / 2);

  logic [FW-1:0] shreg;
  logic [LW-1:0] left;
  logic [SW-1:0] sub;
  logic          bit_end;

  assign bit_end  = active && baud_tick && (sub == SUB_LAST);
  assign coll_hit = active && coll_en && baud_tick && (sub == SUB_MID) && (rxd_loop != txd);
  assign ld_take  = ld_valid && !coll_hit && (!active || (bit_end && left == LW'(1)));

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      txd    <= 1'b1;
      shreg  <= '0;
      left   <= '0;
      sub    <= '0;
    end else if (coll_hit) begin
      active <= 1'b0;
      txd    <= 1'b1;
      sub    <= '0;
    end else if (ld_take) begin
      shreg  <= ld_mask;
      left   <= ld_len;
      sub    <= '0;
      active <= 1'b1;
      txd    <= ~ld_mask[0];
    end else if (bit_end) begin
      sub <= '0;
      if (left == LW'(1)) begin
        active <= 1'b0;
        txd    <= 1'b1;
      end else begin
        shreg <= shreg >> 1;
        left  <= left - LW'(1);
        txd   <= ~shreg[1];
      end
    end else if (active && baud_tick) begin
      sub <= sub + SW'(1);
    end
  end

  // R2
  hold_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (active && !baud_tick) |=> $stable(txd));
endmodule

// File: rtl/lin_uart_tx.sv
module lin_uart_tx
  import lin_tx_pkg::*;
#(
  parameter int OVS  = 4,
  parameter int MAXD = 9
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            baud_tick,
  input  logic            en_set,
  input  logic            en_clr,
  input  logic [2:0]      char_size,
  input  logic            par_en,
  input  logic            par_odd,
  input  logic            two_stop,
  input  logic [1:0]      lin_cmd,
  input  logic            coll_en,
  input  logic [MAXD-1:0] in_data,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic            rxd_loop,
  output logic            txd,
  output logic            busy,
  output logic            tx_on,
  output logic            coll_flag
);
  localparam int CW  = MAXD + 4;
  localparam int HDR = BRK_LOW + 1;
  localparam int FW  = HDR + 2 * CW;
  localparam int LW  = $clog2(FW + 1);

  logic [CW-1:0] m_sync, m_dat;
  logic [LW-1:0] l_sync, l_dat;
  logic [FW-1:0] pk_mask, hold_mask;
  logic [LW-1:0] pk_len, hold_len;
  logic          hold_valid, ld_take, coll_hit, active, accept;

  lin_tx_frame #(.MAXD(MAXD), .CW(CW), .LW(LW)) u_sync (
    .data(MAXD'(8'h55)), .char_size(char_size), .par_en(par_en),
    .par_odd(par_odd), .two_stop(two_stop), .low_mask(m_sync), .len(l_sync));

  lin_tx_frame #(.MAXD(MAXD), .CW(CW), .LW(LW)) u_dat (
    .data(in_data), .char_size(char_size), .par_en(par_en),
    .par_odd(par_odd), .two_stop(two_stop), .low_mask(m_dat), .len(l_dat));

  always_comb begin
    case (lin_cmd_e'(lin_cmd))
      CMD_BREAK: begin
        pk_mask = FW'({BRK_LOW{1'b1}});
        pk_len  = LW'(HDR);
      end
      CMD_HEADER: begin
        pk_mask = FW'({BRK_LOW{1'b1}}) | (FW'(m_sync) << HDR)
                | (FW'(m_dat) << (HDR + int'(l_sync)));
        pk_len  = LW'(HDR) + l_sync + l_dat;
      end
      default: begin
        pk_mask = FW'(m_dat);
        pk_len  = l_dat;
      end
    endcase
  end

  assign in_ready = tx_on && !hold_valid && !en_clr;
  assign accept   = in_valid && in_ready;
  assign busy     = active || hold_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_valid <= 1'b0;
      hold_mask  <= '0;
      hold_len   <= '0;
      tx_on      <= 1'b0;
      coll_flag  <= 1'b0;
    end else begin
      if (coll_hit)     hold_valid <= 1'b0;
      else if (accept) begin
        hold_valid <= 1'b1;
        hold_mask  <= pk_mask;
        hold_len   <= pk_len;
      end else if (ld_take) hold_valid <= 1'b0;

      if (coll_hit)    tx_on <= 1'b0;
      else if (en_clr) tx_on <= 1'b0;
      else if (en_set) tx_on <= 1'b1;

      if (coll_hit)    coll_flag <= 1'b1;
      else if (en_set) coll_flag <= 1'b0;
    end
  end

  lin_tx_serial #(.OVS(OVS), .FW(FW), .LW(LW)) u_ser (
    .clk(clk), .rst(rst), .baud_tick(baud_tick), .coll_en(coll_en),
    .rxd_loop(rxd_loop), .ld_valid(hold_valid), .ld_mask(hold_mask),
    .ld_len(hold_len), .ld_take(ld_take), .coll_hit(coll_hit),
    .active(active), .txd(txd));

  // R1
  idle_high_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> txd);
  // R7
  hold_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (hold_valid && !ld_take && !coll_hit) |=> hold_valid);
  // R8
  accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && !coll_hit) |=> busy);
  // R10
  coll_stop_chk: assert property (@(posedge clk) disable iff (rst)
    coll_hit |=> (txd && !tx_on && coll_flag && !busy));
  // R11
  coll_gate_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(coll_flag) |-> $past(coll_en));
endmodule

// File: tb/lin_uart_tx_tb.sv
module lin_uart_tx_tb;
  localparam int OVS = 4;
  logic clk = 1'b0, rst = 1'b1;
  logic baud_tick = 1'b1, en_set = 0, en_clr = 0, par_en = 0, par_odd = 0;
  logic two_stop = 0, coll_en = 0, in_valid = 0, inject = 0;
  logic [2:0] char_size = 0;
  logic [1:0] lin_cmd = 0;
  logic [8:0] in_data = 0;
  logic in_ready, txd, busy, tx_on, coll_flag, rxd_loop;
  int tests = 0, fails = 0;
  logic [127:0] expv, got;
  int elen;

  always #4 clk = ~clk;
  assign rxd_loop = txd ^ inject;

  lin_uart_tx #(.OVS(OVS), .MAXD(9)) u_dut (
    .clk(clk), .rst(rst), .baud_tick(baud_tick), .en_set(en_set), .en_clr(en_clr),
    .char_size(char_size), .par_en(par_en), .par_odd(par_odd), .two_stop(two_stop),
    .lin_cmd(lin_cmd), .coll_en(coll_en), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .rxd_loop(rxd_loop), .txd(txd), .busy(busy),
    .tx_on(tx_on), .coll_flag(coll_flag));

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic add_bit(input logic b);
    expv[elen] = b;
    elen++;
  endtask

  task automatic add_char(input logic [8:0] d);
    int n;
    logic p;
    case (char_size)
      3'd1: n = 9; 3'd5: n = 5; 3'd6: n = 6; 3'd7: n = 7; default: n = 8;
    endcase
    p = par_odd;
    add_bit(1'b0);
    for (int i = 0; i < n; i++) begin add_bit(d[i]); p = p ^ d[i]; end
    if (par_en) add_bit(p);
    add_bit(1'b1);
    if (two_stop) add_bit(1'b1);
  endtask

  task automatic add_break();
    for (int i = 0; i < 13; i++) add_bit(1'b0);
    add_bit(1'b1);
  endtask

  task automatic push(input logic [8:0] d);
    in_data  = d;
    in_valid = 1'b1;
    for (int t = 0; t < 2000; t++) begin
      if (in_ready) begin @(negedge clk); break; end
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  task automatic capture(input int n);
    got = '1;
    for (int t = 0; t < 4000 && txd; t++) @(negedge clk);
    repeat (OVS / 2) @(negedge clk);
    for (int k = 0; k < n; k++) begin
      got[k] = txd;
      if (k != n - 1) repeat (OVS) @(negedge clk);
    end
  endtask

  task automatic enable();
    @(negedge clk); en_set = 1'b1;
    @(negedge clk); en_set = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int idx;
    logic [8:0] d1, d2;
    int lows;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1", {txd, busy, tx_on, coll_flag, in_ready}, 5'b10000);
    enable();
    // R12 enable sets tx_on
    chk("R12", {tx_on, coll_flag}, 2'b10);

    // R2 R3 R4 R7 sweep of size, parity and stop settings with back-to-back words
    idx = 0;
    for (int cs = 0; cs < 8; cs++)
      for (int pe = 0; pe < 2; pe++)
        for (int po = 0; po < 2; po++)
          for (int ts = 0; ts < 2; ts++) begin
            char_size = 3'(cs); par_en = pe[0]; par_odd = po[0]; two_stop = ts[0];
            d1 = 9'((idx * 37 + 5) & 9'h1FF);
            d2 = ~d1;
            idx++;
            expv = '1; elen = 0;
            add_char(d1); add_char(d2);
            fork
              capture(elen);
              begin push(d1); push(d2); end
            join
            chk($sformatf("R2 R3 R4 R7 cs=%0d pe=%0d po=%0d ts=%0d", cs, pe, po, ts), got, expv);
            repeat (OVS + 2) @(negedge clk);
          end
    chk("R4 idle after pair", {txd, busy}, 2'b10);

    // R5 break only
    char_size = 0; par_en = 0; two_stop = 0;
    expv = '1; elen = 0; add_break();
    lin_cmd = 2'd1;
    fork capture(elen + 12); push(9'h03C); join
    lin_cmd = 2'd0;
    chk("R5 break then idle", got, expv);
    chk("R5 not busy", {txd, busy}, 2'b10);

    // R6 full header, plain format then odd parity with two stops
    for (int v = 0; v < 2; v++) begin
      par_en = v[0]; par_odd = v[0]; two_stop = v[0];
      expv = '1; elen = 0;
      add_break(); add_char(9'h055); add_char(9'h01A + 9'(v));
      lin_cmd = 2'd2;
      fork capture(elen); push(9'h01A + 9'(v)); join
      lin_cmd = 2'd0;
      chk($sformatf("R6 header v=%0d", v), got, expv);
      repeat (OVS + 2) @(negedge clk);
    end
    par_en = 0; par_odd = 0; two_stop = 0;
    // R6 spare command sends a normal character
    expv = '1; elen = 0; add_char(9'h0C3);
    lin_cmd = 2'd3;
    fork capture(elen + 4); push(9'h0C3); join
    lin_cmd = 2'd0;
    chk("R6 spare cmd", got, expv);
    repeat (OVS + 2) @(negedge clk);

    // R11 mismatches ignored with checking off
    coll_en = 0;
    expv = '1; elen = 0; add_char(9'h0A6);
    inject = 1'b1;
    fork capture(elen); push(9'h0A6); join
    chk("R11 frame intact", got, expv);
    inject = 1'b0;
    chk("R11 no flag", {coll_flag, tx_on}, 2'b01);
    repeat (OVS + 2) @(negedge clk);

    // R10 collision drops frame, held word and enable
    coll_en = 1'b1;
    fork
      begin push(9'h0FF); push(9'h011); end
      begin
        for (int t = 0; t < 100 && txd; t++) @(negedge clk);
        repeat (10) @(negedge clk);
        inject = 1'b1;
        repeat (6) @(negedge clk);
        chk("R10 after collision", {txd, busy, tx_on, coll_flag, in_ready}, 5'b10010);
        inject = 1'b0;
      end
    join
    lows = 0;
    for (int t = 0; t < 80; t++) begin @(negedge clk); if (!txd || busy) lows++; end
    chk("R10 held word dropped", lows, 0);
    coll_en = 1'b0;
    enable();
    chk("R12 flag cleared", {tx_on, coll_flag}, 2'b10);

    // R8 disable drains in-flight and held words
    expv = '1; elen = 0; add_char(9'h0B4); add_char(9'h04B);
    fork
      capture(elen);
      begin
        push(9'h0B4); push(9'h04B);
        en_clr = 1'b1; @(negedge clk); en_clr = 1'b0;
        chk("R8 ready drops", {in_ready, tx_on}, 2'b00);
      end
    join
    chk("R8 both sent", got, expv);
    repeat (OVS + 2) @(negedge clk);
    chk("R8 done", {txd, busy}, 2'b10);

    // R9 write in the same cycle as disable
    enable();
    in_data = 9'h000; in_valid = 1'b1; en_clr = 1'b1;
    #1;
    chk("R9 ready low", in_ready, 1'b0);
    @(negedge clk); in_valid = 1'b0; en_clr = 1'b0;
    lows = 0;
    for (int t = 0; t < 60; t++) begin @(negedge clk); if (!txd || busy) lows++; end
    chk("R9 no frame", lows, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule